// File: doc/BRIEF.md
# Stacked-Board Record Merger

Each board in a vertical stack of front-end boards produces its own hit records: a channel byte followed by a time byte. This block merges those records with the records arriving from the board below it and sends the combined stream up the stack toward the top board, which drives the final output. Every local record gets a leading tag byte that carries the board's 4-bit address in its low nibble, with the high nibble zero. A record therefore leaves the block as three bytes: tag, channel, time. Records from the board below already carry their tag, and the block passes them through unchanged from a dedicated buffer of their own.

Local bytes and upstream bytes go into separate byte buffers, each with a valid/ready handshake. An arbiter chooses a source only after that source holds a whole record. It alternates between sources when both are waiting, and once a record has started, every byte of it goes out before any other record. The output is a byte stream with valid/ready. On the bottom board of a stack, the build-time option that removes the upstream path is set. No buffer is then built, and the upstream port never signals ready. Each board adds its buffering and one arbitration cycle per record, so latency grows with the depth of the stack.

Top module: `dcm_stream_merge`

## Requirements
- R1: After reset, out_valid is 0 and loc_ready is 1. up_ready is 1 when the upstream path is built.
- R2: A local record (channel byte, then time byte) leaves as three bytes: tag byte {4'b0000, board_id}, then the channel byte, then the time byte. Local records leave in arrival order.
- R3: An upstream record is three bytes (tag, channel, time). Upstream records leave byte-for-byte unchanged, in arrival order.
- R4: A record is never split. Its three bytes go out consecutively from one source, and out_valid falls only after the last byte has been accepted.
- R5: While out_valid is 1 and out_ready is 0, out_valid and out_data hold their values on the next cycle.
- R6: When the upstream buffer holds UP_DEPTH bytes, up_ready is 0. A byte held on up_data at that time is accepted once space frees, and no byte is lost.
- R7: When both sources hold a complete record at an arbitration point, the source not served last goes first. After reset the local source wins a tie.
- R8: A source is served only after a whole record is buffered (2 local bytes or 3 upstream bytes). A partial record produces no output.
- R9: With HAS_UPSTREAM = 0, up_ready stays 0, up_valid and up_data have no effect, and local records still flow.
- R10: When the local buffer holds LOC_DEPTH bytes, loc_ready is 0 and the next byte waits without loss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| board_id | input | 4 | Address of this board, placed in local tag bytes |
| loc_valid | input | 1 | Local collector byte valid |
| loc_data | input | 8 | Local collector byte (channel, then time) |
| loc_ready | output | 1 | Local buffer can take a byte |
| up_valid | input | 1 | Byte from the board below is valid |
| up_data | input | 8 | Byte from the board below (tag, channel, time) |
| up_ready | output | 1 | Upstream buffer can take a byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte toward the top of the stack |
| out_ready | input | 1 | Receiver above accepts the byte |

## Verification
The main instance is built with LOC_DEPTH = 4 and UP_DEPTH = 6. With these depths a few pushes fill each buffer, so the full conditions on both inputs can be reached. A depth of 6 is also not a power of two, which exercises pointer wrap inside a buffer holding exactly two upstream records. A second instance is built with HAS_UPSTREAM = 0 to cover the bottom-board variant. The round-robin ordering is observed by loading both buffers while the output is stalled and then releasing it.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

    localparam int BYTE_W        = 8;
    localparam int ADDR_W        = 4;
    localparam int LOC_REC_BYTES = 2;
    localparam int UP_REC_BYTES  = 3;
    localparam int OUT_REC_BYTES = 3;

    typedef enum logic {
        SRC_LOC = 1'b0,
        SRC_UP  = 1'b1
    } src_e;

    typedef struct packed {
        logic       busy;
        src_e       src;
        logic [1:0] idx;
    } emit_s;

    function automatic logic [BYTE_W-1:0] tag_byte(input logic [ADDR_W-1:0] id);
        return {{(BYTE_W-ADDR_W){1'b0}}, id};
    endfunction

    function automatic src_e other_src(input src_e s);
        return (s == SRC_LOC) ? SRC_UP : SRC_LOC;
    endfunction

endpackage

// File: rtl/dcm_byte_fifo.sv
module dcm_byte_fifo
    import dcm_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [BYTE_W-1:0] din,
    input  logic              pop,
    output logic [BYTE_W-1:0] dout,
    output logic [CW-1:0]     fill,
    output logic              full
);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     rd_ptr;
    logic              do_push;
    logic              do_pop;

    assign full    = (fill == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (fill != '0);
    assign dout    = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   fill <= fill + CW'(1);
                2'b01:   fill <= fill - CW'(1);
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/dcm_rr_pick.sv
module dcm_rr_pick
    import dcm_pkg::*;
(
    input  logic loc_ok,
    input  logic up_ok,
    input  src_e last_src,
    output logic grant_any,
    output src_e grant_src
);

    always_comb begin
        grant_any = loc_ok || up_ok;
        if (loc_ok && up_ok) begin
            grant_src = other_src(last_src);
        end else if (loc_ok) begin
            grant_src = SRC_LOC;
        end else begin
            grant_src = SRC_UP;
        end
    end

endmodule

// File: rtl/dcm_emitter.sv
module dcm_emitter
    import dcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              grant_any,
    input  src_e              grant_src,
    input  logic [ADDR_W-1:0] board_id,
    input  logic [BYTE_W-1:0] loc_head,
    input  logic [BYTE_W-1:0] up_head,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              loc_pop,
    output logic              up_pop,
    output src_e              last_src,
    output logic              busy,
    output logic              at_tag
);

    localparam logic [1:0] LAST_IDX = 2'(OUT_REC_BYTES - 1);

    emit_s st;
    logic  fire;

    always_comb begin
        busy      = st.busy;
        out_valid = st.busy;
        fire      = st.busy && out_ready;
        at_tag    = st.busy && (st.src == SRC_LOC) && (st.idx == 2'd0);
        if (st.src == SRC_LOC) begin
            out_data = (st.idx == 2'd0) ? tag_byte(board_id) : loc_head;
        end else begin
            out_data = up_head;
        end
        loc_pop = fire && (st.src == SRC_LOC) && (st.idx != 2'd0);
        up_pop  = fire && (st.src == SRC_UP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '{busy: 1'b0, src: SRC_LOC, idx: 2'd0};
            last_src <= SRC_UP;
        end else if (!st.busy) begin
            if (grant_any) begin
                st <= '{busy: 1'b1, src: grant_src, idx: 2'd0};
            end
        end else if (fire) begin
            if (st.idx == LAST_IDX) begin
                st.busy  <= 1'b0;
                st.idx   <= 2'd0;
                last_src <= st.src;
            end else begin
                st.idx <= st.idx + 2'd1;
            end
        end
    end

endmodule

// File: rtl/dcm_stream_merge.sv
module dcm_stream_merge
    import dcm_pkg::*;
#(
    parameter int LOC_DEPTH    = 16,
    parameter int UP_DEPTH     = 32,
    parameter bit HAS_UPSTREAM = 1'b1,
    localparam int LCW         = $clog2(LOC_DEPTH + 1),
    localparam int UCW         = $clog2(UP_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] board_id,
    input  logic       loc_valid,
    input  logic [7:0] loc_data,
    output logic       loc_ready,
    input  logic       up_valid,
    input  logic [7:0] up_data,
    output logic       up_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    input  logic       out_ready
);

    logic [LCW-1:0]    loc_fill;
    logic              loc_full;
    logic [BYTE_W-1:0] loc_head;
    logic              loc_pop;
    logic [UCW-1:0]    up_fill;
    logic              up_full;
    logic [BYTE_W-1:0] up_head;
    logic              up_pop;
    logic              loc_ok;
    logic              up_ok;
    logic              grant_any;
    src_e              grant_src;
    src_e              last_src;
    logic              em_busy;
    logic              em_tag;

    dcm_byte_fifo #(.DEPTH(LOC_DEPTH)) u_loc_buf (
        .clk  (clk),
        .rst  (rst),
        .push (loc_valid),
        .din  (loc_data),
        .pop  (loc_pop),
        .dout (loc_head),
        .fill (loc_fill),
        .full (loc_full)
    );

    assign loc_ready = !loc_full;
    assign loc_ok    = (loc_fill >= LCW'(LOC_REC_BYTES));

    generate
        if (HAS_UPSTREAM) begin : g_up
            dcm_byte_fifo #(.DEPTH(UP_DEPTH)) u_up_buf (
                .clk  (clk),
                .rst  (rst),
                .push (up_valid),
                .din  (up_data),
                .pop  (up_pop),
                .dout (up_head),
                .fill (up_fill),
                .full (up_full)
            );
            assign up_ready = !up_full;
            assign up_ok    = (up_fill >= UCW'(UP_REC_BYTES));
        end else begin : g_bottom
            assign up_head  = '0;
            assign up_fill  = '0;
            assign up_full  = 1'b1;
            assign up_ready = 1'b0;
            assign up_ok    = 1'b0;
        end
    endgenerate

    dcm_rr_pick u_pick (
        .loc_ok    (loc_ok),
        .up_ok     (up_ok),
        .last_src  (last_src),
        .grant_any (grant_any),
        .grant_src (grant_src)
    );

    dcm_emitter u_emit (
        .clk       (clk),
        .rst       (rst),
        .grant_any (grant_any),
        .grant_src (grant_src),
        .board_id  (board_id),
        .loc_head  (loc_head),
        .up_head   (up_head),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .loc_pop   (loc_pop),
        .up_pop    (up_pop),
        .last_src  (last_src),
        .busy      (em_busy),
        .at_tag    (em_tag)
    );

endmodule

// File: rtl/dcm_merge_chk.sv
module dcm_merge_chk #(
    parameter int LOC_DEPTH    = 16,
    parameter int UP_DEPTH     = 32,
    parameter bit HAS_UPSTREAM = 1'b1,
    localparam int LCW         = $clog2(LOC_DEPTH + 1),
    localparam int UCW         = $clog2(UP_DEPTH + 1)
) (
    input logic           clk,
    input logic           rst,
    input logic           out_valid,
    input logic           out_ready,
    input logic [7:0]     out_data,
    input logic           up_ready,
    input logic           loc_ready,
    input logic [LCW-1:0] loc_fill,
    input logic [UCW-1:0] up_fill,
    input logic           em_tag
);

    // R5
    hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R4
    record_whole_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> $past(out_ready));

    // R2
    tag_nibble_chk: assert property (@(posedge clk) disable iff (rst)
        em_tag |-> out_valid && (out_data[7:4] == 4'h0));

    // R6
    up_full_chk: assert property (@(posedge clk) disable iff (rst)
        (up_fill == UCW'(UP_DEPTH)) |-> !up_ready);

    // R10
    loc_full_chk: assert property (@(posedge clk) disable iff (rst)
        (loc_fill == LCW'(LOC_DEPTH)) |-> !loc_ready);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (up_fill <= UCW'(UP_DEPTH)) && (loc_fill <= LCW'(LOC_DEPTH)));

    // R9
    bottom_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !HAS_UPSTREAM |-> !up_ready && (up_fill == '0));

endmodule

bind dcm_stream_merge dcm_merge_chk #(
    .LOC_DEPTH    (LOC_DEPTH),
    .UP_DEPTH     (UP_DEPTH),
    .HAS_UPSTREAM (HAS_UPSTREAM)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .up_ready  (up_ready),
    .loc_ready (loc_ready),
    .loc_fill  (loc_fill),
    .up_fill   (up_fill),
    .em_tag    (em_tag)
);

// File: tb/test_dcm_stream_merge.sv
module test_dcm_stream_merge;

    localparam logic [3:0] BID   = 4'hA;
    localparam logic [3:0] BID_B = 4'h3;
    localparam int WDOG = 20000;

    // {upstream?, byte0, byte1, byte2}; byte0 unused for local entries
    localparam logic [24:0] VEC [6] = '{
        {1'b0, 8'h00, 8'h05, 8'h11},
        {1'b1, 8'h07, 8'h21, 8'h33},
        {1'b0, 8'h00, 8'h2F, 8'hF0},
        {1'b0, 8'h00, 8'h00, 8'hFF},
        {1'b1, 8'h0C, 8'h08, 8'h99},
        {1'b1, 8'h0F, 8'hFF, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       loc_valid = 1'b0;
    logic [7:0] loc_data = '0;
    logic       loc_ready;
    logic       up_valid = 1'b0;
    logic [7:0] up_data = '0;
    logic       up_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b1;

    logic       b_loc_valid = 1'b0;
    logic [7:0] b_loc_data = '0;
    logic       b_loc_ready;
    logic       b_up_valid = 1'b0;
    logic [7:0] b_up_data = '0;
    logic       b_up_ready;
    logic       b_out_valid;
    logic [7:0] b_out_data;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [7:0] got [$];
    logic [7:0] bgot [$];

    always #4 clk = ~clk;

    dcm_stream_merge #(.LOC_DEPTH(4), .UP_DEPTH(6), .HAS_UPSTREAM(1'b1)) i_dcm_stream_merge (
        .clk(clk), .rst(rst), .board_id(BID),
        .loc_valid(loc_valid), .loc_data(loc_data), .loc_ready(loc_ready),
        .up_valid(up_valid), .up_data(up_data), .up_ready(up_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    dcm_stream_merge #(.LOC_DEPTH(4), .UP_DEPTH(6), .HAS_UPSTREAM(1'b0)) i_dcm_stream_merge_bottom (
        .clk(clk), .rst(rst), .board_id(BID_B),
        .loc_valid(b_loc_valid), .loc_data(b_loc_data), .loc_ready(b_loc_ready),
        .up_valid(b_up_valid), .up_data(b_up_data), .up_ready(b_up_ready),
        .out_valid(b_out_valid), .out_data(b_out_data), .out_ready(1'b1)
    );

    // capture between the driving negedge and the next posedge
    always begin
        @(negedge clk);
        #2;
        if (!rst && out_valid && out_ready) got.push_back(out_data);
        if (!rst && b_out_valid) bgot.push_back(b_out_data);
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WDOG) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected < %0d", cycles, WDOG);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        got.delete();
        bgot.delete();
    endtask

    task automatic push_loc(input logic [7:0] b);
        loc_valid = 1'b1;
        loc_data  = b;
        while (!loc_ready) @(negedge clk);
        @(negedge clk);
        loc_valid = 1'b0;
    endtask

    task automatic push_up(input logic [7:0] b);
        up_valid = 1'b1;
        up_data  = b;
        while (!up_ready) @(negedge clk);
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic wait_bytes(input int n);
        int t = 0;
        while (got.size() < n && t < 200) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
    endtask

    task automatic expect_rec(input string tag, input int base,
                              input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        check(tag, (got.size() > base)     ? got[base]     : 8'hxx, b0);
        check(tag, (got.size() > base + 1) ? got[base + 1] : 8'hxx, b1);
        check(tag, (got.size() > base + 2) ? got[base + 2] : 8'hxx, b2);
    endtask

    initial begin
        do_reset();
        // R1 reset state
        check("R1 out_valid", {7'd0, out_valid}, 8'd0);
        check("R1 loc_ready", {7'd0, loc_ready}, 8'd1);
        check("R1 up_ready",  {7'd0, up_ready},  8'd1);

        // table walk: R2 local tagging, R3 upstream pass-through
        for (int i = 0; i < 6; i++) begin
            got.delete();
            if (VEC[i][24]) begin
                push_up(VEC[i][23:16]);
                push_up(VEC[i][15:8]);
                push_up(VEC[i][7:0]);
                wait_bytes(3);
                expect_rec("R3 upstream record", 0, VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
            end else begin
                push_loc(VEC[i][15:8]);
                push_loc(VEC[i][7:0]);
                wait_bytes(3);
                expect_rec("R2 local record", 0, {4'h0, BID}, VEC[i][15:8], VEC[i][7:0]);
            end
            check("R4 exact byte count", 8'(got.size()), 8'd3);
        end

        // R8: a lone local byte produces nothing
        do_reset();
        push_loc(8'h42);
        repeat (6) @(negedge clk);
        check("R8 partial record idle", {7'd0, out_valid}, 8'd0);
        push_loc(8'h43);
        wait_bytes(3);
        expect_rec("R8 completed record", 0, {4'h0, BID}, 8'h42, 8'h43);

        // R7 round robin, R4 no splitting, R5 hold under stall, R10 local full
        do_reset();
        out_ready = 1'b0;
        push_loc(8'h10); push_loc(8'h11);
        push_loc(8'h20); push_loc(8'h21);
        @(negedge clk);
        check("R10 loc_ready when full", {7'd0, loc_ready}, 8'd0);
        push_up(8'h05); push_up(8'h30); push_up(8'h31);
        push_up(8'h06); push_up(8'h40); push_up(8'h41);
        check("R5 valid during stall", {7'd0, out_valid}, 8'd1);
        check("R5 first byte is tag", out_data, {4'h0, BID});
        repeat (3) @(negedge clk);
        check("R5 tag held", out_data, {4'h0, BID});
        check("R5 valid held", {7'd0, out_valid}, 8'd1);
        out_ready = 1'b1;
        wait_bytes(12);
        expect_rec("R7 first local", 0, {4'h0, BID}, 8'h10, 8'h11);
        expect_rec("R7 then upstream", 3, 8'h05, 8'h30, 8'h31);
        expect_rec("R7 local again", 6, {4'h0, BID}, 8'h20, 8'h21);
        expect_rec("R7 upstream again", 9, 8'h06, 8'h40, 8'h41);

        // R6 upstream full: seventh byte waits
        do_reset();
        out_ready = 1'b0;
        push_up(8'h01); push_up(8'h51); push_up(8'h52);
        push_up(8'h02); push_up(8'h61); push_up(8'h62);
        up_valid = 1'b1;
        up_data  = 8'h03;
        repeat (3) @(negedge clk);
        check("R6 up_ready when full", {7'd0, up_ready}, 8'd0);
        out_ready = 1'b1;
        while (!up_ready) @(negedge clk);
        @(negedge clk);
        up_valid = 1'b0;
        push_up(8'h71); push_up(8'h72);
        wait_bytes(9);
        expect_rec("R6 rec a", 0, 8'h01, 8'h51, 8'h52);
        expect_rec("R6 rec b", 3, 8'h02, 8'h61, 8'h62);
        expect_rec("R6 held byte kept", 6, 8'h03, 8'h71, 8'h72);

        // R9 bottom variant
        do_reset();
        b_up_valid = 1'b1;
        b_up_data  = 8'hEE;
        repeat (4) @(negedge clk);
        check("R9 bottom up_ready", {7'd0, b_up_ready}, 8'd0);
        check("R9 upstream ignored", {7'd0, b_out_valid}, 8'd0);
        b_loc_valid = 1'b1; b_loc_data = 8'h2A;
        @(negedge clk);
        b_loc_data = 8'h2B;
        @(negedge clk);
        b_loc_valid = 1'b0;
        repeat (10) @(negedge clk);
        b_up_valid = 1'b0;
        check("R9 bottom byte count", 8'(bgot.size()), 8'd3);
        check("R9 bottom tag", (bgot.size() > 0) ? bgot[0] : 8'hxx, {4'h0, BID_B});
        check("R9 bottom ch",  (bgot.size() > 1) ? bgot[1] : 8'hxx, 8'h2A);
        check("R9 bottom time", (bgot.size() > 2) ? bgot[2] : 8'hxx, 8'h2B);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule